// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Clock Steering

The block shifts bytes out on one data line, paced by a transfer clock. Software-side logic writes a byte into a one-entry buffer. Once the transmitter is enabled, and the clear-to-send input allows it, the byte moves into a shift register and is sent one bit per transfer clock period. The transfer clock comes from one of two sources: an internal divider that sets the half period to 1, 8 or 32 system clock cycles, or an external clock input that is synchronized into the system clock domain.

Configuration inputs choose the bit order, the clock edge on which data changes, inversion of the data line, and the event that raises the interrupt. When the clock is generated internally it can be routed to an alternate output pin. A change of the routing takes effect only between bytes. While the clock goes to the alternate pin, the clear-to-send gate is forced off. If a new byte waits in the buffer when the current one ends, it follows with no gap in the clock.

Top module: `sync_ser_tx`

## Requirements
- R1: While tx_en_i is 0, a byte written to the buffer is not sent: shift_empty_o stays 1, buf_empty_o stays 0 and no transfer clock edge appears.
- R2: The byte is copied into the shift register on the first leading edge of the transfer clock, and its first bit appears on txd_o at that edge. With msb_first_i=0, bit 0 goes first.
- R3: With msb_first_i=1, the byte is sent with bit 7 first.
- R4: With pol_rise_i=0 the clock rests high and data changes on falling edges. With pol_rise_i=1 the clock rests low and data changes on rising edges.
- R5: In internal mode the transfer clock's half period is 1, 8 or 32 system clock cycles for presc_i equal to 0, 1, or 2 and 3.
- R6: After the last bit of a byte, shift_empty_o returns to 1 and the transfer clock rests at its idle level. With irq_on_done_i=1, irq_o pulses in the same cycle that shift_empty_o rises.
- R7: With irq_on_done_i=0, irq_o pulses once per byte, in the cycle the buffer moves into the shift register, which is the cycle of the first leading clock edge.
- R8: With inv_data_i=1, txd_o carries the inverse of every data bit and of the idle level (idle becomes 0).
- R9: With pin_sel_i=2'b11 and an internal clock, the clock is driven on sclk_alt_o and sclk_o rests idle. Any other value drives sclk_o. A pin_sel_i change during a byte takes effect only after the byte ends.
- R10: With cts_en_i=1 and cts_ni=1, no new byte starts, but a byte that has already started completes. While the alternate clock pin is selected, the CTS gate is ignored.
- R11: If the buffer is refilled before the current byte ends, the next byte follows with no extra idle clock period.
- R12: With ext_sel_i=1, data changes on the leading edges of ext_clk_i after synchronization, and sclk_o and sclk_alt_o both rest idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the transmit buffer |
| wdata_i | input | 8 | Byte to write |
| tx_en_i | input | 1 | Transmit enable |
| presc_i | input | 2 | Internal half-period select: 0 gives 1 cycle, 1 gives 8, 2 and 3 give 32 |
| ext_sel_i | input | 1 | 1 selects the external clock |
| ext_clk_i | input | 1 | External transfer clock |
| pol_rise_i | input | 1 | 1 makes data change on rising edges, with the clock idle low |
| msb_first_i | input | 1 | 1 sends the MSB first |
| inv_data_i | input | 1 | Invert the data line |
| irq_on_done_i | input | 1 | 1 selects transmit complete as the interrupt cause, 0 selects buffer empty |
| cts_en_i | input | 1 | Enable the clear-to-send gate |
| cts_ni | input | 1 | Clear to send, active low |
| pin_sel_i | input | 2 | Clock output pin select; 2'b11 selects the alternate pin |
| txd_o | output | 1 | Serial data |
| sclk_o | output | 1 | Main transfer clock output |
| sclk_alt_o | output | 1 | Alternate transfer clock output |
| buf_empty_o | output | 1 | Transmit buffer empty |
| shift_empty_o | output | 1 | Shift register empty (no byte in progress) |
| irq_o | output | 1 | Transmit interrupt pulse |

## Verification
The assertions check on every cycle that a disabled or CTS-blocked engine never starts a byte and that an idle engine keeps both clock pins at rest. They also check that at most one clock pin toggles at any time, that external mode keeps the internal outputs quiet, and that the completion interrupt coincides with the end of a byte and lasts one cycle. Only the bench scenarios show correct data. These scenarios cover bit order, polarity and inversion, the exact half period for each prescale, the placement of the buffer-empty interrupt, the absence of a gap between back-to-back bytes, a steering change deferred to the end of a byte, and a byte that completes after CTS is withdrawn mid-byte.

// File: rtl/sync_ser_tx_pkg.sv
package sync_ser_tx_pkg;
  typedef enum logic [1:0] {
    PRE_FAST = 2'd0,
    PRE_MID  = 2'd1,
    PRE_SLOW = 2'd2
  } presc_e;

  localparam logic [1:0] PIN_ALT = 2'b11;
endpackage

// File: rtl/sync_ser_tx_clkgen.sv
module sync_ser_tx_clkgen
  import sync_ser_tx_pkg::*;
#(
  parameter int DIV_MID = 8,
  parameter int DIV_HI  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] presc_i,
  input  logic       ext_sel_i,
  input  logic       ext_clk_i,
  input  logic       idle_lvl_i,
  input  logic       run_i,
  input  logic       busy_i,
  output logic       lead_o,
  output logic       trail_o,
  output logic       ph_o
);
  localparam int CW = $clog2(DIV_HI) + 1;

  logic [CW-1:0] cnt_q, lim;
  logic          ph_q, tick;
  logic [2:0]    ext_sync_q;

  always_comb begin
    case (presc_e'(presc_i))
      PRE_FAST: lim = '0;
      PRE_MID:  lim = CW'(DIV_MID - 1);
      default:  lim = CW'(DIV_HI - 1);
    endcase
  end

  assign tick = run_i && !ext_sel_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      if (!run_i || ext_sel_i || tick) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
      if (ext_sel_i) ph_q <= 1'b0;
      else if (tick) ph_q <= ~ph_q;
    end
  end

  // two-flop sync plus history for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sync_q <= 3'b111;
    else         ext_sync_q <= {ext_sync_q[1:0], ext_clk_i};
  end

  logic ext_lead, ext_trail;
  assign ext_lead  = (ext_sync_q[2] == idle_lvl_i) && (ext_sync_q[1] != idle_lvl_i);
  assign ext_trail = (ext_sync_q[2] != idle_lvl_i) && (ext_sync_q[1] == idle_lvl_i);

  assign lead_o  = ext_sel_i ? (ext_lead && run_i)   : (tick && !ph_q);
  assign trail_o = ext_sel_i ? (ext_trail && busy_i) : (tick && ph_q);
  assign ph_o    = ph_q;
endmodule

// File: rtl/sync_ser_tx_shifter.sv
module sync_ser_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         lead_i,
  input  logic         trail_i,
  input  logic         msb_first_i,
  output logic         dout_o,
  output logic         busy_o,
  output logic         full_o,
  output logic         load_o,
  output logic         done_o
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST = BW'(W - 1);

  logic [W-1:0]  buf_q, sh_q;
  logic [BW-1:0] bcnt_q;
  logic          full_q, busy_q, dout_q;

  assign load_o = lead_i && !busy_q;
  assign done_o = trail_i && busy_q && (bcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      sh_q   <= '0;
      bcnt_q <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      dout_q <= 1'b1;
    end else begin
      if (load_o) begin
        busy_q <= 1'b1;
        dout_q <= msb_first_i ? buf_q[W-1] : buf_q[0];
        sh_q   <= msb_first_i ? {buf_q[W-2:0], 1'b0} : {1'b0, buf_q[W-1:1]};
      end else if (lead_i && busy_q) begin
        dout_q <= msb_first_i ? sh_q[W-1] : sh_q[0];
        sh_q   <= msb_first_i ? {sh_q[W-2:0], 1'b0} : {1'b0, sh_q[W-1:1]};
      end
      if (trail_i && busy_q) begin
        if (bcnt_q == LAST) begin
          bcnt_q <= '0;
          busy_q <= 1'b0;
          dout_q <= 1'b1;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
      // a write in the load cycle refills the buffer
      if (wr_i) begin
        buf_q  <= wdata_i;
        full_q <= 1'b1;
      end else if (load_o) begin
        full_q <= 1'b0;
      end
    end
  end

  assign dout_o = dout_q;
  assign busy_o = busy_q;
  assign full_o = full_q;
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sync_ser_tx_pkg::*;
#(
  parameter int W       = 8,
  parameter int DIV_MID = 8,
  parameter int DIV_HI  = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tx_en_i,
  input  logic [1:0]   presc_i,
  input  logic         ext_sel_i,
  input  logic         ext_clk_i,
  input  logic         pol_rise_i,
  input  logic         msb_first_i,
  input  logic         inv_data_i,
  input  logic         irq_on_done_i,
  input  logic         cts_en_i,
  input  logic         cts_ni,
  input  logic [1:0]   pin_sel_i,
  output logic         txd_o,
  output logic         sclk_o,
  output logic         sclk_alt_o,
  output logic         buf_empty_o,
  output logic         shift_empty_o,
  output logic         irq_o
);
  logic idle_lvl, lead, trail, ph, busy, full, load, done, dout;
  logic start_ok, run, alt_act, cts_eff, sclk_int, irq_q;
  logic [1:0] pin_q;

  assign idle_lvl = ~pol_rise_i;
  assign alt_act  = (pin_q == PIN_ALT) && !ext_sel_i;
  assign cts_eff  = cts_en_i && !alt_act;
  assign start_ok = tx_en_i && (!cts_eff || !cts_ni);
  assign run      = busy || (start_ok && full);

  sync_ser_tx_clkgen #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .presc_i    (presc_i),
    .ext_sel_i  (ext_sel_i),
    .ext_clk_i  (ext_clk_i),
    .idle_lvl_i (idle_lvl),
    .run_i      (run),
    .busy_i     (busy),
    .lead_o     (lead),
    .trail_o    (trail),
    .ph_o       (ph)
  );

  sync_ser_tx_shifter #(.W(W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .lead_i      (lead),
    .trail_i     (trail),
    .msb_first_i (msb_first_i),
    .dout_o      (dout),
    .busy_o      (busy),
    .full_o      (full),
    .load_o      (load),
    .done_o      (done)
  );

  // steering follows pin_sel_i only between bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (!busy) pin_q <= pin_sel_i;
      irq_q <= irq_on_done_i ? done : load;
    end
  end

  assign sclk_int      = ph ? ~idle_lvl : idle_lvl;
  assign sclk_o        = (!ext_sel_i && !alt_act) ? sclk_int : idle_lvl;
  assign sclk_alt_o    = alt_act ? sclk_int : idle_lvl;
  assign txd_o         = dout ^ inv_data_i;
  assign buf_empty_o   = ~full;
  assign shift_empty_o = ~busy;
  assign irq_o         = irq_q;
endmodule

// File: rtl/sync_ser_tx_chk.sv
module sync_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic cts_en_i,
  input logic cts_ni,
  input logic pol_rise_i,
  input logic ext_sel_i,
  input logic irq_on_done_i,
  input logic alt_act_i,
  input logic sclk_o,
  input logic sclk_alt_o,
  input logic shift_empty_o,
  input logic irq_o
);
  a_r1_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o && !tx_en_i |=> shift_empty_o);

  a_r10_cts_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o && cts_en_i && cts_ni && !alt_act_i |=> shift_empty_o);

  a_r6_clock_rests_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> (sclk_o == ~pol_rise_i) && (sclk_alt_o == ~pol_rise_i));

  a_r9_single_pin_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((sclk_o != ~pol_rise_i) && (sclk_alt_o != ~pol_rise_i)));

  a_r12_ext_outputs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel_i |-> (sclk_o == ~pol_rise_i) && (sclk_alt_o == ~pol_rise_i));

  a_r6_irq_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_on_done_i && $rose(shift_empty_o) |-> irq_o);

  a_r7_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind sync_ser_tx sync_ser_tx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_en_i       (tx_en_i),
  .cts_en_i      (cts_en_i),
  .cts_ni        (cts_ni),
  .pol_rise_i    (pol_rise_i),
  .ext_sel_i     (ext_sel_i),
  .irq_on_done_i (irq_on_done_i),
  .alt_act_i     (alt_act),
  .sclk_o        (sclk_o),
  .sclk_alt_o    (sclk_alt_o),
  .shift_empty_o (shift_empty_o),
  .irq_o         (irq_o)
);

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, tx_en = 0, ext_sel = 0, ext_clk = 1, pol = 0, msb = 0, inv = 0;
  logic irq_done = 0, cts_en = 0, cts_n = 0;
  logic [1:0] presc = 0, pin_sel = 0;
  logic [7:0] wdata = 0;
  logic txd, sclk, sclk_alt, buf_empty, shift_empty, irq;

  always #4 clk = ~clk;  // 125 MHz

  sync_ser_tx u_sync_ser_tx (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .tx_en_i(tx_en),
    .presc_i(presc), .ext_sel_i(ext_sel), .ext_clk_i(ext_clk), .pol_rise_i(pol),
    .msb_first_i(msb), .inv_data_i(inv), .irq_on_done_i(irq_done),
    .cts_en_i(cts_en), .cts_ni(cts_n), .pin_sel_i(pin_sel), .txd_o(txd),
    .sclk_o(sclk), .sclk_alt_o(sclk_alt), .buf_empty_o(buf_empty),
    .shift_empty_o(shift_empty), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, wd = 0;
  bit done_flag = 0;

  // bit receiver and edge monitor, sampled on the falling system clock edge
  logic [255:0] rxv;
  int rxn = 0, irq_cnt = 0, irq_t = 0, main_lead = 0, alt_lead = 0;
  int lead_t [256];
  int trail_t[256];
  logic act_prev = 0, pend = 0, sclk_prev = 1, alt_prev = 1;

  always @(negedge clk) begin
    logic idle, act;
    cyc++;
    idle = ~pol;
    act  = ext_sel ? (ext_clk != idle) : ((sclk != idle) || (sclk_alt != idle));
    if (rst_n) begin
      if (act) pend = txd;
      if (act && !act_prev) lead_t[rxn % 256] = cyc;
      if (!act && act_prev) begin
        rxv[rxn % 256]    = pend;
        trail_t[rxn % 256] = cyc;
        rxn++;
      end
      if (sclk != idle && sclk_prev == idle) main_lead++;
      if (sclk_alt != idle && alt_prev == idle) alt_lead++;
      if (irq) begin irq_cnt++; irq_t = cyc; end
    end
    act_prev  = act;
    sclk_prev = sclk;
    alt_prev  = sclk_alt;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] get_byte(input int base, input bit msbf);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      if (msbf) b[7-i] = rxv[(base+i) % 256];
      else      b[i]   = rxv[(base+i) % 256];
    end
    return b;
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk); wr = 1; wdata = b;
    @(negedge clk); wr = 0;
  endtask

  task automatic wait_bits(input int base, input int n);
    int t = 0;
    while (rxn < base + n && t < 20000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(buf_empty == 1 && shift_empty == 1, "R6 reset flags", {buf_empty, shift_empty}, 2'b11);
    chk(sclk == 1 && sclk_alt == 1 && txd == 1 && irq == 0, "R6 reset idle",
        {sclk, sclk_alt, txd, irq}, 4'b1110);
  endtask

  task automatic t_enable;
    int base = rxn;
    tx_en = 0;
    send(8'h3C);
    repeat (40) @(negedge clk);
    chk(rxn == base && shift_empty == 1 && buf_empty == 0, "R1 disabled hold",
        {rxn - base, shift_empty, buf_empty}, 2);
    tx_en = 1;
    wait_bits(base, 8);
    chk(get_byte(base, 0) == 8'h3C, "R2 first byte", get_byte(base, 0), 8'h3C);
  endtask

  task automatic t_lsb;
    int base = rxn;
    send(8'hA5);
    wait_bits(base, 8);
    chk(get_byte(base, 0) == 8'hA5, "R2 lsb first", get_byte(base, 0), 8'hA5);
  endtask

  task automatic t_msb;
    int base = rxn;
    msb = 1;
    send(8'h1E);
    wait_bits(base, 8);
    chk(get_byte(base, 1) == 8'h1E, "R3 msb first", get_byte(base, 1), 8'h1E);
    msb = 0;
  endtask

  task automatic t_pol;
    int base;
    pol = 1;
    repeat (2) @(negedge clk);
    chk(sclk == 0, "R4 idle low", sclk, 0);
    base = rxn;
    send(8'h5A);
    wait_bits(base, 8);
    chk(get_byte(base, 0) == 8'h5A, "R4 rising data", get_byte(base, 0), 8'h5A);
    chk(sclk == 0 && shift_empty == 1, "R4 rest low", sclk, 0);
    pol = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_presc;
    int base = rxn;
    presc = 1;
    send(8'hC3);
    wait_bits(base, 8);
    chk(trail_t[(base+7)%256] - lead_t[base%256] == 15*8, "R5 half period 8",
        trail_t[(base+7)%256] - lead_t[base%256], 120);
    chk(get_byte(base, 0) == 8'hC3, "R5 data /8", get_byte(base, 0), 8'hC3);
    base = rxn;
    presc = 2;
    send(8'h96);
    wait_bits(base, 8);
    chk(trail_t[(base+7)%256] - lead_t[base%256] == 15*32, "R5 half period 32",
        trail_t[(base+7)%256] - lead_t[base%256], 480);
    presc = 0;
  endtask

  task automatic t_irq_done;
    int base = rxn, i0 = irq_cnt;
    irq_done = 1;
    repeat (2) @(negedge clk);
    send(8'h77);
    wait_bits(base, 8);
    chk(irq_cnt - i0 == 1, "R6 one irq", irq_cnt - i0, 1);
    chk(irq_t == trail_t[(base+7)%256], "R6 irq at done", irq_t, trail_t[(base+7)%256]);
    chk(shift_empty == 1 && sclk == 1, "R6 rest high", {shift_empty, sclk}, 2'b11);
  endtask

  task automatic t_irq_empty;
    int base = rxn, i0 = irq_cnt;
    irq_done = 0;
    repeat (2) @(negedge clk);
    send(8'h42);
    wait_bits(base, 8);
    chk(irq_cnt - i0 == 1, "R7 one irq", irq_cnt - i0, 1);
    chk(irq_t == lead_t[base%256], "R7 irq at load", irq_t, lead_t[base%256]);
  endtask

  task automatic t_inv;
    int base = rxn;
    inv = 1;
    repeat (2) @(negedge clk);
    chk(txd == 0, "R8 idle inverted", txd, 0);
    send(8'h6B);
    wait_bits(base, 8);
    chk(get_byte(base, 0) == 8'h94, "R8 data inverted", get_byte(base, 0), 8'h94);
    inv = 0;
  endtask

  task automatic t_steer;
    int base = rxn, m0 = main_lead, a0 = alt_lead, t = 0;
    pin_sel = 2'b11;
    repeat (2) @(negedge clk);
    send(8'hF0);
    while (rxn < base + 2 && t < 2000) begin @(negedge clk); t++; end
    pin_sel = 2'b00;
    wait_bits(base, 8);
    chk(main_lead == m0 && alt_lead - a0 == 8, "R9 alt pin held",
        main_lead - m0, 0);
    chk(get_byte(base, 0) == 8'hF0, "R9 alt data", get_byte(base, 0), 8'hF0);
    base = rxn; m0 = main_lead; a0 = alt_lead;
    send(8'h0F);
    wait_bits(base, 8);
    chk(main_lead - m0 == 8 && alt_lead == a0, "R9 main pin", main_lead - m0, 8);
  endtask

  task automatic t_cts;
    int base = rxn, t = 0;
    cts_en = 1; cts_n = 1;
    send(8'h55);
    repeat (40) @(negedge clk);
    chk(rxn == base && shift_empty == 1, "R10 cts blocks", rxn - base, 0);
    cts_n = 0;
    while (rxn < base + 3 && t < 2000) begin @(negedge clk); t++; end
    cts_n = 1;
    wait_bits(base, 8);
    chk(rxn == base + 8 && get_byte(base, 0) == 8'h55, "R10 byte completes",
        get_byte(base, 0), 8'h55);
    pin_sel = 2'b11;
    repeat (2) @(negedge clk);
    base = rxn;
    send(8'h99);
    wait_bits(base, 8);
    chk(get_byte(base, 0) == 8'h99 && rxn == base + 8, "R10 gate off on alt pin",
        get_byte(base, 0), 8'h99);
    pin_sel = 2'b00; cts_en = 0; cts_n = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_b2b;
    int base = rxn, t = 0;
    presc = 1;
    send(8'h12);
    while (buf_empty == 0 && t < 2000) begin @(negedge clk); t++; end
    send(8'h34);
    wait_bits(base, 16);
    chk(get_byte(base, 0) == 8'h12 && get_byte(base + 8, 0) == 8'h34, "R11 two bytes",
        get_byte(base + 8, 0), 8'h34);
    chk(trail_t[(base+15)%256] - lead_t[base%256] == 31*8, "R11 no gap",
        trail_t[(base+15)%256] - lead_t[base%256], 248);
    presc = 0;
  endtask

  task automatic t_ext;
    int base, m0 = main_lead, a0 = alt_lead;
    ext_clk = 1; ext_sel = 1;
    repeat (4) @(negedge clk);
    base = rxn;
    send(8'hE7);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ext_clk = 0; repeat (10) @(negedge clk);
      ext_clk = 1; repeat (10) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk(get_byte(base, 0) == 8'hE7, "R12 ext data", get_byte(base, 0), 8'hE7);
    chk(main_lead == m0 && alt_lead == a0 && shift_empty == 1, "R12 outputs quiet",
        main_lead - m0, 0);
    ext_sel = 0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_lsb();
    t_msb();
    t_pol();
    t_presc();
    t_irq_done();
    t_irq_empty();
    t_inv();
    t_steer();
    t_cts();
    t_b2b();
    t_ext();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule